// File: doc/BRIEF.md
# Configuration Stream Packet Processor

This block takes a configuration stream delivered either one bit or one byte per clock, aligns it on a sync pattern, and packs it into 32-bit words. After sync, each word is read as part of a packet. A packet is a header word, which names a target register and a word count, followed by that many payload words.

Each payload word passes through a holding stage. A write stage then delivers it to the addressed register. Ordinary registers appear on a write port. Two registers drive the frame engine: one loads the frame address, and one accepts frame data. A third register carries the expected CRC, which is compared against a CRC-16 accumulated over all earlier payload words.

Frame data is collected into frames of `ROWS` rows of 80 bits each. A frame is emitted one row per cycle, and each row is split into a left half and a right half. After each frame the frame address advances by itself. The number of frames in a column depends on the column's type.

Top module: `cfg_pkt_proc`

## Requirements
- R1: After reset `synced_o`, `reg_wr_o`, `crc_error_o` and `frame_valid_o` are low.
- R2: No header is parsed until the word 0xAA995566 has been seen. Anything received earlier causes no register write. In bit mode the pattern is found at any bit offset; in byte mode it is found on byte boundaries. `synced_o` rises once it is found and stays high.
- R3: In bit mode `din_i[0]` is taken MSB-first into each word. In byte mode `din_i` is taken as bytes, most significant byte first. Only cycles with `din_valid_i` high count.
- R4: Header fields are: opcode in bits [31:27], register address in bits [26:13], word count in bits [10:0]. Opcode 1 is a write. Every other opcode is skipped, whatever its count field holds. A write with count 0 is an empty packet, and the next word is a header.
- R5: Each payload word addressed to any register other than 2 produces one `reg_wr_o` pulse carrying its address and data, in stream order. All words of a multi-word packet go to the packet's address.
- R6: The CRC starts at zero. For every payload word not addressed to register 0, it is updated over the 46-bit message {address, data}, MSB first, using polynomial x^16+x^15+x^2+1 (feedback = crc[15] XOR bit, shift left, XOR 0x8005 when feedback is 1). After each write to register 0 the CRC returns to zero.
- R7: A write to register 0 whose bits [15:0] differ from the running CRC sets `crc_error_o`, which stays high until reset. A matching write leaves it low.
- R8: While `crc_error_o` is high, frame-data words are dropped and no new frame is emitted.
- R9: Words written to register 2 fill a frame of ROWS*80/32 words. A full frame produces ROWS consecutive `frame_valid_o` cycles with row index 0 first. Row r carries frame bits [ROWS*80-1-80r -: 80], where the first word received occupies the top bits; the upper 40 bits of the row go on `frame_left_o` and the lower 40 bits on `frame_right_o`.
- R10: Column types by index c of NUM_COLS columns: c=0 or last → IOB with 4 frames; c=1 or last-1 → IOI with 22; c=NUM_COLS/2 → clock with 4; c mod 4 = 3 → BRAM with 84; otherwise CLB with 22. After each frame the minor address increments. Past the column's last frame it wraps to 0 in the next column, and the last column wraps to column 0.
- R11: A write to register 1 loads the column from bits [15:8] and the minor address from bits [7:0]. It also discards any partly collected frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_mode_i | input | 1 | 1: byte per cycle, 0: bit per cycle |
| din_valid_i | input | 1 | Stream data valid |
| din_i | input | 8 | Stream data (bit mode uses bit 0) |
| synced_o | output | 1 | Sync pattern found |
| reg_wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | 14 | Register write address |
| reg_data_o | output | 32 | Register write data |
| crc_error_o | output | 1 | Sticky CRC mismatch |
| frame_valid_o | output | 1 | Row output strobe |
| frame_row_o | output | $clog2(ROWS) | Row index within frame |
| frame_col_o | output | 8 | Column of emitted frame |
| frame_minor_o | output | 8 | Minor frame index within column |
| frame_left_o | output | 40 | Left half of row |
| frame_right_o | output | 40 | Right half of row |

## Verification
The assertions watch on every cycle several properties: the error flag never falls once set, no frame begins after an error, rows come out in order starting at 0, an emitted minor address is always below its column's frame count, frame-data writes never appear on the register port, and nothing is written before sync. Other properties need known stimulus, so only the bench scenarios show them. These are bit-offset alignment in serial mode, byte ordering, skipping of NOP and empty packets, actual CRC values against corrupted checks, the exact data in each row half, address wrap across IOB, BRAM, clock and last-column boundaries, and the dropping of a partial frame when a new address is loaded.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [31:0] SYNC_WORD = 32'hAA995566;
  localparam logic [4:0]  OP_WRITE  = 5'h01;
  localparam logic [13:0] REG_CRC   = 14'd0;
  localparam logic [13:0] REG_FAR   = 14'd1;
  localparam logic [13:0] REG_FDRI  = 14'd2;
  localparam int ROW_BITS  = 80;
  localparam int HALF_BITS = 40;
  localparam int CW = 8;  // column field width
  localparam int MW = 8;  // minor field width

  typedef enum logic [2:0] {CT_IOB, CT_IOI, CT_CLB, CT_BRAM, CT_GCLK} col_type_e;

  function automatic col_type_e col_type(input logic [CW-1:0] col, input int ncols);
    if (int'(col) == 0 || int'(col) == ncols - 1) return CT_IOB;
    if (int'(col) == 1 || int'(col) == ncols - 2) return CT_IOI;
    if (int'(col) == ncols / 2) return CT_GCLK;
    if (col[1:0] == 2'd3) return CT_BRAM;
    return CT_CLB;
  endfunction

  function automatic logic [MW-1:0] col_frames(input logic [CW-1:0] col, input int ncols);
    case (col_type(col, ncols))
      CT_IOB, CT_GCLK: return MW'(4);
      CT_BRAM:         return MW'(84);
      default:         return MW'(22);
    endcase
  endfunction

  function automatic logic [15:0] crc16_upd(input logic [15:0] crc, input logic [45:0] msg);
    logic [15:0] c;
    logic fb;
    c = crc;
    for (int i = 45; i >= 0; i--) begin
      fb = c[15] ^ msg[i];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
    end
    return c;
  endfunction
endpackage

// File: rtl/cfg_word_packer.sv
module cfg_word_packer
  import cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_mode_i,
  input  logic        din_valid_i,
  input  logic [7:0]  din_i,
  output logic        synced_o,
  output logic        word_v_o,
  output logic [31:0] word_o
);
  logic [31:0] sh_q, sh_nx;
  logic [5:0]  cnt_q, step, cnt_nx;

  always_comb begin
    sh_nx  = byte_mode_i ? {sh_q[23:0], din_i} : {sh_q[30:0], din_i[0]};
    step   = byte_mode_i ? 6'd8 : 6'd1;
    cnt_nx = cnt_q + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      synced_o <= 1'b0;
      word_v_o <= 1'b0;
      word_o   <= '0;
    end else begin
      word_v_o <= 1'b0;
      if (din_valid_i) begin
        sh_q <= sh_nx;
        if (!synced_o) begin
          if (sh_nx == SYNC_WORD) begin
            synced_o <= 1'b1;
            cnt_q    <= '0;
          end
        end else if (cnt_nx == 6'd32) begin
          word_v_o <= 1'b1;
          word_o   <= sh_nx;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_pkt_parser.sv
module cfg_pkt_parser
  import cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        word_v_i,
  input  logic [31:0] word_i,
  output logic        reg_wr_o,
  output logic [13:0] reg_addr_o,
  output logic [31:0] reg_data_o,
  output logic        fdri_v_o,
  output logic        far_v_o,
  output logic        crc_error_o
);
  typedef enum logic {ST_HDR, ST_PAY} pst_e;
  pst_e        st_q;
  logic [10:0] rem_q;
  logic [13:0] addr_q, hold_addr_q;
  logic [31:0] hold_q;
  logic        hold_v_q;
  logic [15:0] crc_q;

  // header and hold stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_HDR;
      rem_q       <= '0;
      addr_q      <= '0;
      hold_q      <= '0;
      hold_addr_q <= '0;
      hold_v_q    <= 1'b0;
    end else begin
      hold_v_q <= 1'b0;
      if (word_v_i) begin
        if (st_q == ST_HDR) begin
          if (word_i[31:27] == OP_WRITE && word_i[10:0] != '0) begin
            st_q   <= ST_PAY;
            addr_q <= word_i[26:13];
            rem_q  <= word_i[10:0];
          end
        end else begin
          hold_q      <= word_i;
          hold_addr_q <= addr_q;
          hold_v_q    <= 1'b1;
          rem_q       <= rem_q - 11'd1;
          if (rem_q == 11'd1) st_q <= ST_HDR;
        end
      end
    end
  end

  // write stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q       <= '0;
      crc_error_o <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_data_o  <= '0;
      fdri_v_o    <= 1'b0;
      far_v_o     <= 1'b0;
    end else begin
      reg_wr_o <= 1'b0;
      fdri_v_o <= 1'b0;
      far_v_o  <= 1'b0;
      if (hold_v_q) begin
        reg_addr_o <= hold_addr_q;
        reg_data_o <= hold_q;
        reg_wr_o   <= (hold_addr_q != REG_FDRI);
        fdri_v_o   <= (hold_addr_q == REG_FDRI);
        far_v_o    <= (hold_addr_q == REG_FAR);
        if (hold_addr_q == REG_CRC) begin
          if (hold_q[15:0] != crc_q) crc_error_o <= 1'b1;
          crc_q <= '0;
        end else begin
          crc_q <= crc16_upd(crc_q, {hold_addr_q, hold_q});
        end
      end
    end
  end
endmodule

// File: rtl/cfg_frame_engine.sv
module cfg_frame_engine
  import cfg_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int ROWS     = 2,   // even, so a frame is whole words
  localparam int FB      = ROWS * ROW_BITS,
  localparam int WPF     = FB / 32,
  localparam int WC_W    = $clog2(WPF + 1),
  localparam int RW      = $clog2(ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fdri_v_i,
  input  logic                 far_v_i,
  input  logic                 halt_i,
  input  logic [31:0]          data_i,
  output logic                 frame_valid_o,
  output logic [RW-1:0]        frame_row_o,
  output logic [CW-1:0]        frame_col_o,
  output logic [MW-1:0]        frame_minor_o,
  output logic [HALF_BITS-1:0] frame_left_o,
  output logic [HALF_BITS-1:0] frame_right_o
);
  logic [FB-1:0]   buf_q;
  logic [WC_W-1:0] wcnt_q;
  logic            em_q;
  logic [RW-1:0]   row_q;
  logic [CW-1:0]   col_q;
  logic [MW-1:0]   min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q         <= '0;
      wcnt_q        <= '0;
      em_q          <= 1'b0;
      row_q         <= '0;
      col_q         <= '0;
      min_q         <= '0;
      frame_valid_o <= 1'b0;
      frame_row_o   <= '0;
      frame_col_o   <= '0;
      frame_minor_o <= '0;
      frame_left_o  <= '0;
      frame_right_o <= '0;
    end else begin
      frame_valid_o <= 1'b0;
      if (far_v_i) begin
        col_q  <= data_i[15:8];
        min_q  <= data_i[7:0];
        wcnt_q <= '0;
      end else if (fdri_v_i && !halt_i) begin
        buf_q <= {buf_q[FB-33:0], data_i};
        if (wcnt_q == WC_W'(WPF - 1)) begin
          wcnt_q <= '0;
          em_q   <= 1'b1;
          row_q  <= '0;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
      // rows move up one per cycle; words are spaced wider than ROWS cycles
      if (em_q) begin
        frame_valid_o <= 1'b1;
        frame_row_o   <= row_q;
        frame_col_o   <= col_q;
        frame_minor_o <= min_q;
        frame_left_o  <= buf_q[FB-1 -: HALF_BITS];
        frame_right_o <= buf_q[FB-1-HALF_BITS -: HALF_BITS];
        buf_q         <= buf_q << ROW_BITS;
        if (row_q == RW'(ROWS - 1)) begin
          em_q <= 1'b0;
          if (min_q == col_frames(col_q, NUM_COLS) - 1'b1) begin
            min_q <= '0;
            col_q <= (int'(col_q) == NUM_COLS - 1) ? '0 : col_q + 1'b1;
          end else begin
            min_q <= min_q + 1'b1;
          end
        end else begin
          row_q <= row_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_pkt_proc.sv
module cfg_pkt_proc
  import cfg_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int ROWS     = 2,
  localparam int RW      = $clog2(ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 byte_mode_i,
  input  logic                 din_valid_i,
  input  logic [7:0]           din_i,
  output logic                 synced_o,
  output logic                 reg_wr_o,
  output logic [13:0]          reg_addr_o,
  output logic [31:0]          reg_data_o,
  output logic                 crc_error_o,
  output logic                 frame_valid_o,
  output logic [RW-1:0]        frame_row_o,
  output logic [CW-1:0]        frame_col_o,
  output logic [MW-1:0]        frame_minor_o,
  output logic [HALF_BITS-1:0] frame_left_o,
  output logic [HALF_BITS-1:0] frame_right_o
);
  logic        word_v, fdri_v, far_v;
  logic [31:0] word;

  cfg_word_packer u_packer (
    .clk_i, .rst_ni, .byte_mode_i, .din_valid_i, .din_i,
    .synced_o, .word_v_o(word_v), .word_o(word)
  );

  cfg_pkt_parser u_parser (
    .clk_i, .rst_ni, .word_v_i(word_v), .word_i(word),
    .reg_wr_o, .reg_addr_o, .reg_data_o,
    .fdri_v_o(fdri_v), .far_v_o(far_v), .crc_error_o
  );

  cfg_frame_engine #(.NUM_COLS(NUM_COLS), .ROWS(ROWS)) u_frame (
    .clk_i, .rst_ni, .fdri_v_i(fdri_v), .far_v_i(far_v), .halt_i(crc_error_o),
    .data_i(reg_data_o), .frame_valid_o, .frame_row_o, .frame_col_o,
    .frame_minor_o, .frame_left_o, .frame_right_o
  );
endmodule

// File: rtl/cfg_pkt_proc_chk.sv
module cfg_pkt_proc_chk
  import cfg_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int ROWS     = 2,
  localparam int RW      = $clog2(ROWS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          synced_o,
  input logic          reg_wr_o,
  input logic [13:0]   reg_addr_o,
  input logic          crc_error_o,
  input logic          frame_valid_o,
  input logic [RW-1:0] frame_row_o,
  input logic [CW-1:0] frame_col_o,
  input logic [MW-1:0] frame_minor_o
);
  assert_no_wr_before_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_o |-> !reg_wr_o);
  assert_no_frame_on_reg_port_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> reg_addr_o != REG_FDRI);
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_error_o |=> crc_error_o);
  assert_no_frame_after_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_error_o && !frame_valid_o) |=> !frame_valid_o);
  assert_row_starts_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) |-> frame_row_o == '0);
  assert_row_sequence_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o && int'(frame_row_o) != ROWS - 1) |=>
      (frame_valid_o && frame_row_o == $past(frame_row_o) + 1'b1));
  assert_minor_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o && int'(frame_col_o) < NUM_COLS) |->
      frame_minor_o < col_frames(frame_col_o, NUM_COLS));
endmodule

bind cfg_pkt_proc cfg_pkt_proc_chk #(.NUM_COLS(NUM_COLS), .ROWS(ROWS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .synced_o(synced_o), .reg_wr_o(reg_wr_o),
  .reg_addr_o(reg_addr_o), .crc_error_o(crc_error_o), .frame_valid_o(frame_valid_o),
  .frame_row_o(frame_row_o), .frame_col_o(frame_col_o), .frame_minor_o(frame_minor_o)
);

// File: tb/cfg_pkt_proc_bench.sv
module cfg_pkt_proc_bench;
  localparam int NUM_COLS = 8;
  localparam int ROWS = 2;

  logic clk = 1'b0, rst_n = 1'b0, byte_mode = 1'b0, din_valid = 1'b0;
  logic [7:0] din = '0;
  logic synced, reg_wr, crc_err, fv;
  logic [13:0] reg_addr;
  logic [31:0] reg_data;
  logic [0:0] frow;
  logic [7:0] fcol, fmin;
  logic [39:0] fl, fr;

  always #5 clk = ~clk;

  cfg_pkt_proc #(.NUM_COLS(NUM_COLS), .ROWS(ROWS)) u_cfg_pkt_proc (
    .clk_i(clk), .rst_ni(rst_n), .byte_mode_i(byte_mode), .din_valid_i(din_valid),
    .din_i(din), .synced_o(synced), .reg_wr_o(reg_wr), .reg_addr_o(reg_addr),
    .reg_data_o(reg_data), .crc_error_o(crc_err), .frame_valid_o(fv),
    .frame_row_o(frow), .frame_col_o(fcol), .frame_minor_o(fmin),
    .frame_left_o(fl), .frame_right_o(fr)
  );

  int checks = 0, fails = 0, cyc = 0;
  int wr_n = 0, fr_n = 0, sent_n = 0;
  logic [13:0] wr_a [256];
  logic [31:0] wr_d [256];
  logic [7:0]  fr_c [256], fr_m [256];
  logic        fr_r [256];
  logic [39:0] fr_l [256], fr_rt [256];
  logic [31:0] sent_w [512];
  logic [15:0] crc_m = '0;

  // write-port and frame-port logs, sampled away from the clock edge
  always @(negedge clk) begin
    if (rst_n && reg_wr) begin wr_a[wr_n] = reg_addr; wr_d[wr_n] = reg_data; wr_n++; end
    if (rst_n && fv) begin
      fr_c[fr_n] = fcol; fr_m[fr_n] = fmin; fr_r[fr_n] = frow[0];
      fr_l[fr_n] = fl; fr_rt[fr_n] = fr; fr_n++;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] c0, input logic [13:0] a, input logic [31:0] d);
    logic [45:0] m;
    logic [15:0] c;
    m = {a, d};
    c = c0;
    for (int i = 45; i >= 0; i--) begin
      if (c[15] ^ m[i]) c = {c[14:0], 1'b0} ^ 16'h8005;
      else c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    if (byte_mode) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); din_valid = 1'b1; din = w[31-8*i -: 8];
      end
    end else begin
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); din_valid = 1'b1; din = {7'b0, w[31-i]};
      end
    end
    @(negedge clk); din_valid = 1'b0; din = 8'hA5;
  endtask

  function automatic logic [31:0] hdr(input logic [4:0] op, input logic [13:0] a, input logic [10:0] n);
    return {op, a, 2'b00, n};
  endfunction

  task automatic wr_pkt(input logic [13:0] a, input logic [31:0] d);
    send_word(hdr(5'h01, a, 11'd1));
    send_word(d);
    if (a != 14'd0) crc_m = crc_ref(crc_m, a, d);
  endtask

  task automatic crc_check(input bit good);
    logic [31:0] d;
    d = {16'h0, good ? crc_m : (crc_m ^ 16'h0001)};
    send_word(hdr(5'h01, 14'd0, 11'd1));
    send_word(d);
    crc_m = '0;
    idle(4);
  endtask

  task automatic send_fdri(input int nw);
    logic [31:0] w;
    send_word(hdr(5'h01, 14'd2, 11'(nw)));
    for (int i = 0; i < nw; i++) begin
      w = {sent_n[15:0], 16'h5A00 ^ 16'(sent_n * 37)} ^ 32'h9E37_0000;
      sent_w[sent_n] = w; sent_n++;
      send_word(w);
      crc_m = crc_ref(crc_m, 14'd2, w);
    end
    idle(6);
  endtask

  task automatic chk_frame(input int f, input int s, input logic [7:0] c, input logic [7:0] m);
    logic [159:0] e;
    e = {sent_w[s], sent_w[s+1], sent_w[s+2], sent_w[s+3], sent_w[s+4]};
    chk(fr_n >= f + 2, "R9 frame emitted", 64'(fr_n), 64'(f + 2));
    chk(fr_c[f] == c && fr_m[f] == m && fr_c[f+1] == c && fr_m[f+1] == m,
        "R10 frame address", {fr_c[f], fr_m[f], fr_c[f+1], fr_m[f+1]}, {c, m, c, m});
    chk(fr_r[f] == 1'b0 && fr_r[f+1] == 1'b1, "R9 row order", {fr_r[f], fr_r[f+1]}, 64'h1);
    chk(fr_l[f] == e[159:120] && fr_rt[f] == e[119:80], "R9 row0 halves", {fr_l[f], 24'h0}, {e[159:120], 24'h0});
    chk(fr_l[f+1] == e[79:40] && fr_rt[f+1] == e[39:0], "R9 row1 halves", {fr_l[f+1], 24'h0}, {e[79:40], 24'h0});
  endtask

  task automatic do_reset(input logic bm);
    rst_n = 1'b0; byte_mode = bm; din_valid = 1'b0;
    wr_n = 0; fr_n = 0; crc_m = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  // {addr, data}: register writes walked in one loop
  localparam logic [45:0] VEC [8] = '{
    {14'h0004, 32'h0000_0001}, {14'h3FFF, 32'hFFFF_FFFF}, {14'h0010, 32'h8000_0000},
    {14'h0001, 32'h0000_0302}, {14'h2AAA, 32'hAA99_5566}, {14'h0005, 32'h0000_0000},
    {14'h1234, 32'hDEAD_BEEF}, {14'h0003, 32'h1357_9BDF}
  };

  initial begin
    int i0, f0, s0;
    // ---- bit mode run ----
    do_reset(1'b0);
    chk(!synced && !reg_wr && !crc_err && !fv, "R1 reset outputs",
        {synced, reg_wr, crc_err, fv}, 64'h0);
    for (int i = 0; i < 5; i++) begin @(negedge clk); din_valid = 1'b1; din = {7'b0, i[0]}; end
    send_word(hdr(5'h01, 14'h0007, 11'd1));
    send_word(32'h1111_2222);
    idle(4);
    chk(!synced && wr_n == 0, "R2 pre-sync ignored", {synced, 32'(wr_n)}, 64'h0);
    send_word(32'hAA99_5566);
    chk(synced, "R2 sync at odd bit offset", 64'(synced), 64'h1);
    for (int k = 0; k < 8; k++) begin
      i0 = wr_n;
      wr_pkt(VEC[k][45:32], VEC[k][31:0]);
      idle(4);
      chk(wr_n == i0 + 1, "R5 one write per word", 64'(wr_n), 64'(i0 + 1));
      chk(wr_a[i0] == VEC[k][45:32] && wr_d[i0] == VEC[k][31:0], "R3 R5 bit mode write",
          {wr_a[i0], wr_d[i0]}, {VEC[k][45:32], VEC[k][31:0]});
    end
    i0 = wr_n;
    send_word(hdr(5'h00, 14'h0006, 11'd3));
    send_word(hdr(5'h01, 14'h0009, 11'd0));
    send_word(hdr(5'h01, 14'h0006, 11'd2));
    send_word(32'hCAFE_0001); crc_m = crc_ref(crc_m, 14'h6, 32'hCAFE_0001);
    send_word(32'hCAFE_0002); crc_m = crc_ref(crc_m, 14'h6, 32'hCAFE_0002);
    idle(4);
    chk(wr_n == i0 + 2, "R4 NOP and empty skipped", 64'(wr_n), 64'(i0 + 2));
    chk(wr_a[i0] == 14'h6 && wr_d[i0] == 32'hCAFE_0001 && wr_a[i0+1] == 14'h6 && wr_d[i0+1] == 32'hCAFE_0002,
        "R5 multi-word packet", {wr_d[i0], wr_d[i0+1]}, 64'hCAFE0001_CAFE0002);
    crc_check(1'b1);
    chk(!crc_err, "R6 R7 good CRC accepted", 64'(crc_err), 64'h0);

    // ---- byte mode run ----
    do_reset(1'b1);
    wr_pkt(14'h0005, 32'h7777_7777);
    idle(4);
    chk(wr_n == 0 && !synced, "R2 byte mode pre-sync", 64'(wr_n), 64'h0);
    send_word(32'hAA99_5566);
    crc_m = '0;
    i0 = wr_n;
    wr_pkt(14'h0021, 32'h0102_0304);
    idle(4);
    chk(wr_n == i0 + 1 && wr_d[i0] == 32'h0102_0304, "R3 byte order", 64'(wr_d[i0]), 64'h01020304);
    // IOB -> IOI boundary
    wr_pkt(14'd1, 32'h0000_0002);
    f0 = fr_n; s0 = sent_n;
    send_fdri(15);
    chk_frame(f0, s0, 8'd0, 8'd2); chk_frame(f0 + 2, s0 + 5, 8'd0, 8'd3); chk_frame(f0 + 4, s0 + 10, 8'd1, 8'd0);
    // BRAM -> clock column
    wr_pkt(14'd1, 32'h0000_0352);
    f0 = fr_n; s0 = sent_n;
    send_fdri(15);
    chk_frame(f0, s0, 8'd3, 8'd82); chk_frame(f0 + 2, s0 + 5, 8'd3, 8'd83); chk_frame(f0 + 4, s0 + 10, 8'd4, 8'd0);
    // clock column -> CLB
    wr_pkt(14'd1, 32'h0000_0403);
    f0 = fr_n; s0 = sent_n;
    send_fdri(10);
    chk_frame(f0, s0, 8'd4, 8'd3); chk_frame(f0 + 2, s0 + 5, 8'd5, 8'd0);
    // last column wraps to column 0
    wr_pkt(14'd1, 32'h0000_0703);
    f0 = fr_n; s0 = sent_n;
    send_fdri(10);
    chk_frame(f0, s0, 8'd7, 8'd3); chk_frame(f0 + 2, s0 + 5, 8'd0, 8'd0);
    // address reload discards a partial frame
    wr_pkt(14'd1, 32'h0000_0200);
    f0 = fr_n;
    send_fdri(2);
    chk(fr_n == f0, "R11 partial frame held", 64'(fr_n), 64'(f0));
    wr_pkt(14'd1, 32'h0000_0515);
    s0 = sent_n;
    send_fdri(10);
    chk_frame(f0, s0, 8'd5, 8'd21); chk_frame(f0 + 2, s0 + 5, 8'd6, 8'd0);
    crc_check(1'b1);
    chk(!crc_err, "R7 good CRC over frames", 64'(crc_err), 64'h0);
    wr_pkt(14'h0008, 32'h0BAD_0BAD);
    crc_check(1'b0);
    chk(crc_err, "R7 bad CRC flagged", 64'(crc_err), 64'h1);
    f0 = fr_n;
    send_fdri(5);
    chk(fr_n == f0, "R8 frames halted", 64'(fr_n), 64'(f0));
    crc_check(1'b1);
    chk(crc_err, "R7 error sticky", 64'(crc_err), 64'h1);
    summary();
  end
endmodule